// File: doc/BRIEF.md
# Locked 8-Byte Compare-Exchange Sequencer

This block performs the memory half of an 8-byte compare-and-exchange over a 32-bit, single-outstanding bus master port. A start pulse captures an operand address, a 64-bit compare value, a 64-bit replacement value and a lock request. The block then reads the 64-bit memory operand, compares it with the compare value, and writes back either the replacement value (on a match) or the unchanged old value (on a mismatch). When it finishes it reports the old value and a match flag.

Read and write cycles are never merged. An operand on a dword boundary takes two full-dword reads and then two full-dword writes. An operand at any other offset splits each of its dwords into two partial cycles, so it takes four reads and then four writes. Both reads and writes go lower dword first, and within a split the lower-addressed piece goes first. When the lock is requested, the bus lock stays asserted from the first read until the final write is acknowledged. An unlocked operation issues exactly the same sequence with the lock low.

Top module: `cx8_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `bus_req`, `bus_lock`, `busy` and `done` are low.
- R2: With `op_addr[1:0]==0`, the block issues exactly four bus cycles: a read of dword `op_addr`, a read of `op_addr+4`, a write to `op_addr` and a write to `op_addr+4`, each with `bus_be=4'hF`. Byte lane k (`data[8k+7:8k]`) carries the byte at `bus_addr+k`, and operand byte i (`bits[8i+7:8i]`) is the byte at `op_addr+i`.
- R3: With offset o=`op_addr[1:0]` nonzero, the block issues four reads and then four writes. Each phase visits D, D+4, D+4 and D+8, where D=`op_addr` with its low two bits cleared. The byte enables alternate: lanes o..3 for the first and third cycles, lanes 0..o-1 for the second and fourth.
- R4: With `lock_req` set at start, `bus_lock` is high in every cycle from the first read request up to and including the cycle in which the final write receives `bus_rdy`, and is low from the following cycle on.
- R5: With `lock_req` clear at start, the bus sequence is identical to the locked one and `bus_lock` never rises.
- R6: If the memory operand equals `cmp_val`, the writes carry `swap_val` and `match` is 1.
- R7: If the memory operand differs from `cmp_val`, the writes carry the operand read, unchanged, and `match` is 0.
- R8: `done` is high for exactly one cycle, the cycle after the final write receives `bus_rdy`, and `old_val` then holds the 64-bit operand read from memory.
- R9: A `start` pulse while `busy` is high is ignored. The running sequence, its values and its results are unaffected, and no further operation starts.
- R10: While `bus_req` is high and `bus_rdy` is low, `bus_addr`, `bus_be` and `bus_wr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| lock_req | input | 1 | Run the whole sequence under bus lock |
| op_addr | input | ADDR_W | Byte address of the 64-bit operand |
| cmp_val | input | 64 | Value compared with memory |
| swap_val | input | 64 | Value written on a match |
| bus_addr | output | ADDR_W | Dword-aligned bus address |
| bus_be | output | 4 | Byte-lane enables |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_lock | output | 1 | Bus lock |
| bus_req | output | 1 | Cycle request, held until ready |
| bus_rdy | input | 1 | Cycle completes at this edge |
| bus_rdata | input | 32 | Read data |
| bus_wdata | output | 32 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| match | output | 1 | Memory equaled compare value |
| old_val | output | 64 | Operand read from memory |

## Verification
On every cycle, the embedded assertions check four things: the request stays stable while it waits for ready, no enabled cycle has empty byte enables, the lock does not drop between a locked read and the following cycle, and the done pulse lasts one cycle, lands right after a write acknowledgement, and finds the lock already released. The order of the cycles, the split byte enables at each offset, the write data chosen by the compare, the values left in memory and the rejection of a second start can only be shown by the bench's scenarios. There, a behavioural memory with random ready stalls is compared against an expected transaction queue.

// File: rtl/cx8_pkg.sv
`timescale 1ns/1ps
package cx8_pkg;
  localparam int LANES      = 4;
  localparam int LANE_W     = 8;
  localparam int BUS_W      = LANES * LANE_W;
  localparam int OFS_W      = $clog2(LANES);
  localparam int OPND_BYTES = 8;
  localparam int OPND_W     = OPND_BYTES * LANE_W;
  localparam int WIN_WORDS  = OPND_BYTES / LANES + 1;
  localparam int WIN_W      = WIN_WORDS * BUS_W;
  localparam int WIN_IDX_W  = $clog2(WIN_W);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CMP   = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } cx_state_e;
endpackage

// File: rtl/cx8_lane_map.sv
`timescale 1ns/1ps
// Maps a step of a read or write phase to the bus dword and byte lanes.
module cx8_lane_map
  import cx8_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        step,
  output logic [ADDR_W-1:0] word_addr,
  output logic [1:0]        word_idx,
  output logic [LANES-1:0]  lane_en,
  output logic              last_step
);
  logic [OFS_W-1:0] ofs;
  logic [LANES-1:0] upper_lanes;

  always_comb begin
    ofs         = base_addr[OFS_W-1:0];
    upper_lanes = {LANES{1'b1}} << ofs;
    if (ofs == '0) begin
      word_idx  = {1'b0, step[0]};
      lane_en   = {LANES{1'b1}};
      last_step = step[0];
    end else begin
      // split: piece order D, D+4, D+4, D+8; upper lanes then lower lanes
      word_idx  = {step == 2'd3, (step == 2'd1) || (step == 2'd2)};
      lane_en   = step[0] ? ~upper_lanes : upper_lanes;
      last_step = (step == 2'd3);
    end
    word_addr = {base_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}}
              + ADDR_W'({word_idx, {OFS_W{1'b0}}});
  end
endmodule

// File: rtl/cx8_window.sv
`timescale 1ns/1ps
// Three-dword byte window covering the operand at any offset.
module cx8_window
  import cx8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_en,
  input  logic              merge_en,
  input  logic [1:0]        word_idx,
  input  logic [LANES-1:0]  lane_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [BUS_W-1:0]  rdata,
  input  logic [OPND_W-1:0] merge_val,
  output logic [OPND_W-1:0] operand,
  output logic [BUS_W-1:0]  wdata
);
  logic [WIN_W-1:0] win_q, win_d;
  logic             win_en;

  always_comb begin
    win_d = win_q;
    if (clear) begin
      win_d = '0;
    end else begin
      if (cap_en) begin
        for (int k = 0; k < LANES; k++) begin
          if (lane_en[k]) begin
            win_d[WIN_IDX_W'(32'(word_idx) * BUS_W + k * LANE_W) +: LANE_W] =
              rdata[k*LANE_W +: LANE_W];
          end
        end
      end
      if (merge_en) begin
        for (int i = 0; i < OPND_BYTES; i++) begin
          win_d[WIN_IDX_W'((32'(ofs) + i) * LANE_W) +: LANE_W] =
            merge_val[i*LANE_W +: LANE_W];
        end
      end
    end
  end

  assign win_en = clear | cap_en | merge_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign operand = win_q[WIN_IDX_W'(32'(ofs) * LANE_W) +: OPND_W];
  assign wdata   = win_q[WIN_IDX_W'(32'(word_idx) * BUS_W) +: BUS_W];
endmodule

// File: rtl/cx8_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: read phase, compare, write phase, completion.
module cx8_ctrl
  import cx8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       lock_req,
  input  logic       last_step,
  input  logic       bus_rdy,
  output logic [1:0] step,
  output logic       take_args,
  output logic       cap_en,
  output logic       merge_en,
  output logic       bus_req,
  output logic       bus_wr,
  output logic       bus_lock,
  output logic       done,
  output logic       busy
);
  cx_state_e  state_q, state_d;
  logic [1:0] step_q, step_d;
  logic       lock_q, lock_d;

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    lock_d    = lock_q;
    take_args = 1'b0;
    cap_en    = 1'b0;
    merge_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          take_args = 1'b1;
          state_d   = ST_READ;
          step_d    = 2'd0;
          lock_d    = lock_req;
        end
      end
      ST_READ: begin
        if (bus_rdy) begin
          cap_en = 1'b1;
          if (last_step) begin
            state_d = ST_CMP;
            step_d  = 2'd0;
          end else begin
            step_d = step_q + 2'd1;
          end
        end
      end
      ST_CMP: begin
        merge_en = 1'b1;
        state_d  = ST_WRITE;
      end
      ST_WRITE: begin
        if (bus_rdy) begin
          if (last_step) begin
            state_d = ST_DONE;
            step_d  = 2'd0;
            lock_d  = 1'b0;
          end else begin
            step_d = step_q + 2'd1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: begin
        state_d = ST_IDLE;
        lock_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      lock_q  <= lock_d;
    end
  end

  assign step     = step_q;
  assign bus_req  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_wr   = (state_q == ST_WRITE);
  assign bus_lock = lock_q && ((state_q == ST_READ) || (state_q == ST_CMP) ||
                               (state_q == ST_WRITE));
  assign done     = (state_q == ST_DONE);
  assign busy     = (state_q != ST_IDLE);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rdy && bus_lock && !bus_wr) |=> bus_lock);
  // R4
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_lock);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_req && bus_wr && bus_rdy));
endmodule

// File: rtl/cx8_seq.sv
`timescale 1ns/1ps
module cx8_seq
  import cx8_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              lock_req,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [63:0]       cmp_val,
  input  logic [63:0]       swap_val,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_be,
  output logic              bus_wr,
  output logic              bus_lock,
  output logic              bus_req,
  input  logic              bus_rdy,
  input  logic [31:0]       bus_rdata,
  output logic [31:0]       bus_wdata,
  output logic              busy,
  output logic              done,
  output logic              match,
  output logic [63:0]       old_val
);
  logic [ADDR_W-1:0] addr_q;
  logic [OPND_W-1:0] cmp_q, swap_q, old_q, operand, merge_val;
  logic              match_q, match_d;
  logic [1:0]        step, word_idx;
  logic [LANES-1:0]  lane_en;
  logic              last_step, take_args, cap_en, merge_en;

  // argument capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmp_q  <= '0;
      swap_q <= '0;
    end else if (take_args) begin
      addr_q <= op_addr;
      cmp_q  <= cmp_val;
      swap_q <= swap_val;
    end
  end

  cx8_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lock_req  (lock_req),
    .last_step (last_step),
    .bus_rdy   (bus_rdy),
    .step      (step),
    .take_args (take_args),
    .cap_en    (cap_en),
    .merge_en  (merge_en),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_lock  (bus_lock),
    .done      (done),
    .busy      (busy)
  );

  cx8_lane_map #(.ADDR_W(ADDR_W)) u_map (
    .base_addr (addr_q),
    .step      (step),
    .word_addr (bus_addr),
    .word_idx  (word_idx),
    .lane_en   (lane_en),
    .last_step (last_step)
  );

  // compare and select the write-back value
  always_comb begin
    match_d   = (operand == cmp_q);
    merge_val = match_d ? swap_q : operand;
  end

  cx8_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (take_args),
    .cap_en    (cap_en),
    .merge_en  (merge_en),
    .word_idx  (word_idx),
    .lane_en   (lane_en),
    .ofs       (addr_q[OFS_W-1:0]),
    .rdata     (bus_rdata),
    .merge_val (merge_val),
    .operand   (operand),
    .wdata     (bus_wdata)
  );

  // result registers, loaded in the compare cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q   <= '0;
      match_q <= 1'b0;
    end else if (merge_en) begin
      old_q   <= operand;
      match_q <= match_d;
    end
  end

  assign bus_be  = bus_req ? lane_en : '0;
  assign old_val = old_q;
  assign match   = match_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) &&
                               $stable(bus_be) && $stable(bus_wr)));
  // R3
  lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_be != 4'h0));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !bus_lock && !done));
endmodule

// File: tb/cx8_seq_test.sv
`timescale 1ns/1ps
module cx8_seq_test;
  typedef struct packed {
    logic [31:0] a;
    logic [3:0]  be;
    logic        wr;
    logic [31:0] d;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, lock_req = 1'b0, bus_rdy = 1'b0;
  logic [31:0] op_addr = '0, bus_rdata = '0;
  logic [63:0] cmp_val = '0, swap_val = '0;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_wr, bus_lock, bus_req, busy, done, match;
  logic [63:0] old_val;

  logic [7:0]  mem [0:63];
  exp_t        q[$];
  logic        exp_lock = 1'b0, exp_match = 1'b0, done_due = 1'b0, op_over = 1'b0;
  logic [63:0] exp_old = '0;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cx8_seq uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus responder and cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_due) begin
        check(done === 1'b1, "R8", "done pulse", 64'(done), 64'd1);
        check(old_val === exp_old, "R8", "old_val", old_val, exp_old);
        check(match === exp_match, exp_match ? "R6" : "R7", "match flag",
              64'(match), 64'(exp_match));
        done_due = 1'b0;
        op_over  = 1'b1;
      end else if (done !== 1'b0) begin
        check(1'b0, "R8", "unexpected done", 64'(done), 64'd0);
      end
      bus_rdy = 1'b0;
      if (bus_req) begin
        if (bus_lock !== exp_lock)
          check(1'b0, exp_lock ? "R4" : "R5", "lock during cycle",
                64'(bus_lock), 64'(exp_lock));
        if (q.size() == 0) begin
          check(1'b0, "R9", "extra bus request", 64'(bus_addr), 64'd0);
        end else if (($urandom % 3) != 0) begin
          exp_t e;
          bit   dok;
          e = q.pop_front();
          bus_rdy = 1'b1;
          check(bus_addr === e.a && bus_be === e.be && bus_wr === e.wr,
                bus_addr[1:0] == 2'd0 && e.be == 4'hF && exp_old[0] === 1'bx ? "R2" :
                (e.be == 4'hF ? "R2" : "R3"), "cycle addr/be/wr",
                {27'd0, bus_wr, bus_be, bus_addr},
                {27'd0, e.wr, e.be, e.a});
          for (int k = 0; k < 4; k++)
            bus_rdata[8*k +: 8] = mem[(bus_addr + k) % 64];
          if (e.wr) begin
            dok = 1'b1;
            for (int k = 0; k < 4; k++)
              if (e.be[k]) begin
                if (bus_wdata[8*k +: 8] !== e.d[8*k +: 8]) dok = 1'b0;
                mem[(bus_addr + k) % 64] = bus_wdata[8*k +: 8];
              end
            check(dok, exp_match ? "R6" : "R7", "write data",
                  64'(bus_wdata), 64'(e.d));
            if (q.size() == 0) done_due = 1'b1;
          end
        end
      end else if (!busy) begin
        if (bus_lock !== 1'b0)
          check(1'b0, "R4", "lock while idle", 64'(bus_lock), 64'd0);
      end
    end
  end

  task automatic push_pieces(input logic [31:0] addr, input bit wr,
                             input logic [63:0] val);
    for (int h = 0; h < 2; h++) begin
      logic [31:0] s, d0;
      int o;
      s  = addr + 32'(4 * h);
      d0 = {s[31:2], 2'b00};
      o  = int'(s[1:0]);
      for (int p = 0; p < ((o == 0) ? 1 : 2); p++) begin
        exp_t e;
        e.a  = d0 + 32'(4 * p);
        e.be = (o == 0) ? 4'hF : (p == 0 ? (4'hF << o) : ~(4'hF << o));
        e.wr = wr;
        e.d  = '0;
        for (int k = 0; k < 4; k++) begin
          int bi;
          bi = int'(e.a) + k - int'(addr);
          if (bi >= 0 && bi < 8) e.d[8*k +: 8] = val[8*bi +: 8];
        end
        q.push_back(e);
      end
    end
  endtask

  task automatic run_op(input logic [31:0] addr, input bit want_match,
                        input logic [63:0] swp, input bit lk, input bit poke);
    logic [63:0] old, cmpv, wval;
    logic [7:0]  spare [0:7];
    for (int i = 0; i < 8; i++) old[8*i +: 8] = mem[(addr + i) % 64];
    for (int i = 0; i < 8; i++) spare[i] = mem[40 + i];
    cmpv      = want_match ? old : old ^ 64'h0000_0100_0000_0001;
    wval      = want_match ? swp : old;
    exp_old   = old;
    exp_match = want_match;
    exp_lock  = lk;
    op_over   = 1'b0;
    q.delete();
    push_pieces(addr, 1'b0, old);
    push_pieces(addr, 1'b1, wval);
    @(negedge clk);
    op_addr = addr; cmp_val = cmpv; swap_val = swp; lock_req = lk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R9: second start while busy, with different arguments
      op_addr = 32'd40; cmp_val = '0; swap_val = '1; lock_req = ~lk; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 400 && !op_over; t++) @(negedge clk);
    check(op_over, "R8", "operation completed", 64'(op_over), 64'd1);
    check(q.size() == 0, lk ? "R4" : "R5", "all cycles issued",
          64'(q.size()), 64'd0);
    for (int i = 0; i < 8; i++)
      check(mem[(addr + i) % 64] === wval[8*i +: 8], want_match ? "R6" : "R7",
            "memory after op", 64'(mem[(addr + i) % 64]), 64'(wval[8*i +: 8]));
    repeat (4) @(negedge clk);
    check(!bus_req && !bus_lock && !busy, "R1", "quiet after op",
          {61'd0, bus_req, bus_lock, busy}, 64'd0);
    if (poke) begin
      for (int i = 0; i < 8; i++)
        check(mem[40 + i] === spare[i], "R9", "ignored start left memory",
              64'(mem[40 + i]), 64'(spare[i]));
    end
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    check(!bus_req && !bus_lock && !done && !busy, "R1", "reset state",
          {60'd0, bus_req, bus_lock, done, busy}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!bus_req && !bus_lock && !done && !busy, "R1", "idle after reset",
          {60'd0, bus_req, bus_lock, done, busy}, 64'd0);
    run_op(32'd8,  1'b1, 64'h1122_3344_5566_7788, 1'b1, 1'b0); // R2 R4 R6
    run_op(32'd16, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0); // R2 R7
    run_op(32'd21, 1'b1, 64'hA5A5_5A5A_C3C3_3C3C, 1'b1, 1'b0); // R3 offset 1
    run_op(32'd34, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0); // R3 offset 2
    run_op(32'd3,  1'b1, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b0); // R3 R5 offset 3
    run_op(32'd24, 1'b0, 64'h7777_8888_9999_AAAA, 1'b0, 1'b0); // R5 aligned
    run_op(32'd13, 1'b1, 64'h0F0F_F0F0_1234_4321, 1'b1, 1'b1); // R9 R10
    run_op(32'd0,  1'b1, 64'hCAFE_D00D_5555_AAAA, 1'b0, 1'b1); // R9 unlocked
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule